// File: doc/BRIEF.md
# Voltage Margining PWM Controller

This block drives one pulse-width-modulated output that sets, trims or margins the voltage of a single power rail through an external filter. A 16-bit configuration word chooses one of four idle behaviours, the relation between duty and rail voltage, whether rail faults are masked during margining, and a pad number. Each clock the block also takes a margin request (none, low or high), three voltage codes (nominal target, margin-low and margin-high), a measured voltage code from an upstream converter and a preset duty value.

The PWM period is a fixed number of clocks. Everything visible at the output changes only on a period boundary: the live configuration, the sampled margin request and the duty value. This keeps every pulse whole. In closed-loop operation a bang-bang integrator compares the measured code against the selected setpoint once per period. It moves the duty by one step, holds inside a one-code deadband, and saturates at zero and at a full period. Over- and under-voltage fault inputs pass to the fault outputs unless masking is enabled and a margin is in force.

Top module: `margin_pwm_ctrl`

## Requirements
- R1: After reset the configuration is all zero (disabled), `pwm_oe` and `pwm_out` are low and `cfg_rdata` and `pin_sel` read zero.
- R2: A write stores the fields in word bits 15:14 (mode), 13 (fault mask), 12 (polarity) and 4:0 (pad number). Bits 11:5 are discarded and read back as zero on `cfg_rdata`. `pin_sel` shows the pad number of the live configuration.
- R3: A written configuration becomes live at the first period boundary after the write, and not before.
- R4: Mode 00 (disabled): `pwm_oe` and `pwm_out` stay low, margin requests are ignored, the duty register is cleared, and faults pass through unmasked.
- R5: Mode 01 (high impedance): `pwm_oe` is high only while a margin request is in force. Outside margining the duty is held.
- R6: Mode 11 (fixed): outside margining the duty loaded at each boundary is `fixed_duty`, clipped to the period length.
- R7: Mode 10 (trim), and any enabled mode while margining: once per period the duty moves by exactly one step toward the setpoint. It holds when the measured code is within one code of the setpoint, and it saturates at 0 and at the period length.
- R8: With polarity bit 1, a measured code below the setpoint raises the duty. With polarity 0 the direction is reversed.
- R9: `margin_req` 01 selects `mlow_code` and 10 selects `mhigh_code` as the setpoint. 00 and 11 mean no margin, and the setpoint is then `target_code`. The request is sampled at period boundaries.
- R10: With fault-mask bit 13 set and a margin in force, `ov_out` and `uv_out` are low. Otherwise they equal `ov_in` and `uv_in`.
- R11: `pwm_out` is high for the first `duty` clocks of each period, is low for the rest, and is never high while `pwm_oe` is low. The duty changes only at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Stored configuration, reserved bits zero |
| pin_sel | output | 5 | Pad number from the live configuration |
| margin_req | input | 2 | Margin request: 00 none, 01 low, 10 high, 11 none |
| target_code | input | VW | Nominal voltage setpoint |
| mlow_code | input | VW | Margin-low setpoint |
| mhigh_code | input | VW | Margin-high setpoint |
| meas_code | input | VW | Measured rail voltage code |
| fixed_duty | input | CNT_W | Preset duty for fixed mode |
| ov_in | input | 1 | Over-voltage fault in |
| uv_in | input | 1 | Under-voltage fault in |
| pwm_out | output | 1 | PWM output |
| pwm_oe | output | 1 | Pad output enable |
| ov_out | output | 1 | Gated over-voltage fault |
| uv_out | output | 1 | Gated under-voltage fault |

## Verification
The hardest situation to reach is the pipeline skew at a boundary. There the configuration, the sampled request and the duty update all change together, and the update still uses the previous period's mode and request. The stimulus changes one input exactly at a period start, tracked by a free cycle count in the bench. It then follows the per-period pulse count across several periods, so the one-period lag of each source shows up as a known sequence of duty values. The deadband edges, saturation at both ends and a closed loop are reached by driving the measured code as a function of the pulse count just measured.

// File: rtl/margin_pwm_pkg.sv
package margin_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_HIZ   = 2'b01,
    MODE_TRIM  = 2'b10,
    MODE_FIXED = 2'b11
  } mg_mode_e;

  typedef struct packed {
    mg_mode_e   mode;
    logic       flt_mask;
    logic       pol_up;
    logic [4:0] pin;
  } mg_cfg_t;

  localparam logic [1:0] REQ_LOW  = 2'b01;
  localparam logic [1:0] REQ_HIGH = 2'b10;

  function automatic mg_cfg_t cfg_unpack(input logic [15:0] w);
    mg_cfg_t c;
    c.mode     = mg_mode_e'(w[15:14]);
    c.flt_mask = w[13];
    c.pol_up   = w[12];
    c.pin      = w[4:0];
    return c;
  endfunction

  function automatic logic [15:0] cfg_pack(input mg_cfg_t c);
    return {c.mode, c.flt_mask, c.pol_up, 7'b0, c.pin};
  endfunction

endpackage

// File: rtl/margin_cfg_regs.sv
module margin_cfg_regs
  import margin_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        tick,
  output mg_cfg_t     pend_q,
  output mg_cfg_t     live_q
);

  mg_cfg_t pend_d, live_d;

  always_comb begin
    pend_d = pend_q;
    live_d = live_q;
    if (wr_en) pend_d = cfg_unpack(wdata);
    if (tick)  live_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      live_q <= '0;
    end else begin
      pend_q <= pend_d;
      live_q <= live_d;
    end
  end

endmodule

// File: rtl/margin_pwm_timebase.sv
module margin_pwm_timebase #(
  parameter int CNT_W  = 10,
  parameter int PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/margin_trim_loop.sv
module margin_trim_loop
  import margin_pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PERIOD = 1000,
  parameter int VW     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  mg_mode_e         mode,
  input  logic             pol_up,
  input  logic             marg,
  input  logic [VW-1:0]    setpoint,
  input  logic [VW-1:0]    meas,
  input  logic [CNT_W-1:0] fixed_duty,
  output logic [CNT_W-1:0] duty_q
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(PERIOD);

  logic [VW:0]      meas_x, sp_x;
  logic             below, above, go_up, go_dn;
  logic [CNT_W-1:0] stepped, fixed_clip, upd, duty_d;

  always_comb begin
    meas_x = {1'b0, meas};
    sp_x   = {1'b0, setpoint};
    below  = (meas_x + 1'b1) < sp_x;
    above  = meas_x > (sp_x + 1'b1);
    go_up  = pol_up ? below : above;
    go_dn  = pol_up ? above : below;

    stepped = duty_q;
    if (go_up && (duty_q < FULL))      stepped = duty_q + 1'b1;
    else if (go_dn && (duty_q != '0))  stepped = duty_q - 1'b1;

    fixed_clip = (fixed_duty > FULL) ? FULL : fixed_duty;

    unique case (mode)
      MODE_OFF:   upd = '0;
      MODE_HIZ:   upd = marg ? stepped : duty_q;
      MODE_TRIM:  upd = stepped;
      MODE_FIXED: upd = marg ? stepped : fixed_clip;
      default:    upd = '0;
    endcase

    duty_d = tick ? upd : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

endmodule

// File: rtl/margin_pwm_ctrl.sv
module margin_pwm_ctrl
  import margin_pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PERIOD = 1000,
  parameter int VW     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic [4:0]       pin_sel,
  input  logic [1:0]       margin_req,
  input  logic [VW-1:0]    target_code,
  input  logic [VW-1:0]    mlow_code,
  input  logic [VW-1:0]    mhigh_code,
  input  logic [VW-1:0]    meas_code,
  input  logic [CNT_W-1:0] fixed_duty,
  input  logic             ov_in,
  input  logic             uv_in,
  output logic             pwm_out,
  output logic             pwm_oe,
  output logic             ov_out,
  output logic             uv_out
);

  mg_cfg_t          cfg_pend, cfg_live;
  logic             tick;
  logic [CNT_W-1:0] cnt_q, duty_q;
  logic [1:0]       req_q, req_d;
  logic             marg_live;
  logic [VW-1:0]    setpoint;
  logic [1:0]       live_mode;
  logic             live_mask;
  logic [8:0]       live_bits;

  margin_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .tick(tick), .pend_q(cfg_pend), .live_q(cfg_live)
  );

  margin_pwm_timebase #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .tick(tick)
  );

  always_comb req_d = tick ? margin_req : req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  always_comb begin
    marg_live = (cfg_live.mode != MODE_OFF) &&
                ((req_q == REQ_LOW) || (req_q == REQ_HIGH));
    unique case (req_q)
      REQ_LOW:  setpoint = mlow_code;
      REQ_HIGH: setpoint = mhigh_code;
      default:  setpoint = target_code;
    endcase
  end

  margin_trim_loop #(.CNT_W(CNT_W), .PERIOD(PERIOD), .VW(VW)) u_loop (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mode(cfg_live.mode), .pol_up(cfg_live.pol_up), .marg(marg_live),
    .setpoint(setpoint), .meas(meas_code), .fixed_duty(fixed_duty),
    .duty_q(duty_q)
  );

  always_comb begin
    unique case (cfg_live.mode)
      MODE_OFF:   pwm_oe = 1'b0;
      MODE_HIZ:   pwm_oe = marg_live;
      default:    pwm_oe = 1'b1;
    endcase
    pwm_out   = pwm_oe && (cnt_q < duty_q);
    ov_out    = ov_in && !(cfg_live.flt_mask && marg_live);
    uv_out    = uv_in && !(cfg_live.flt_mask && marg_live);
    cfg_rdata = cfg_pack(cfg_pend);
    pin_sel   = cfg_live.pin;
    live_mode = cfg_live.mode;
    live_mask = cfg_live.flt_mask;
    live_bits = cfg_live;
  end

endmodule

// File: rtl/margin_pwm_ctrl_chk.sv
module margin_pwm_ctrl_chk #(
  parameter int CNT_W  = 10,
  parameter int PERIOD = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic             mask,
  input logic             marg,
  input logic [8:0]       live_bits,
  input logic [CNT_W-1:0] duty,
  input logic [CNT_W-1:0] fixed_duty,
  input logic             pwm_out,
  input logic             pwm_oe,
  input logic             ov_out,
  input logic             uv_out
);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(live_bits));

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!pwm_oe && !pwm_out));

  p_hiz_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !marg) |-> !pwm_oe);

  p_fixed_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b11 && !marg) |=>
      (duty == (($past(fixed_duty) > CNT_W'(PERIOD)) ? CNT_W'(PERIOD) : $past(fixed_duty))));

  p_trim_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b10) |=>
      ((duty == $past(duty)) || (duty == $past(duty) + 1'b1) ||
       ((duty != '1) && (duty + 1'b1 == $past(duty)))));

  p_duty_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= CNT_W'(PERIOD));

  p_fault_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (marg && mask) |-> (!ov_out && !uv_out));

  p_duty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(duty));

  p_pwm_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> pwm_oe);

endmodule

bind margin_pwm_ctrl margin_pwm_ctrl_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(live_mode), .mask(live_mask),
  .marg(marg_live), .live_bits(live_bits), .duty(duty_q), .fixed_duty(fixed_duty),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe), .ov_out(ov_out), .uv_out(uv_out)
);

// File: tb/margin_pwm_ctrl_test.sv
`timescale 1ns/1ps
module margin_pwm_ctrl_test;

  localparam int P     = 16;
  localparam int CNT_W = 10;
  localparam int VW    = 10;

  logic             clk, rst_n, cfg_wr;
  logic [15:0]      cfg_wdata, cfg_rdata;
  logic [4:0]       pin_sel;
  logic [1:0]       margin_req;
  logic [VW-1:0]    target_code, mlow_code, mhigh_code, meas_code;
  logic [CNT_W-1:0] fixed_duty;
  logic             ov_in, uv_in, pwm_out, pwm_oe, ov_out, uv_out;

  int vectors = 0;
  int miscompares = 0;
  int unsigned ncyc;

  margin_pwm_ctrl #(.CNT_W(CNT_W), .PERIOD(P), .VW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pin_sel(pin_sel), .margin_req(margin_req),
    .target_code(target_code), .mlow_code(mlow_code), .mhigh_code(mhigh_code),
    .meas_code(meas_code), .fixed_duty(fixed_duty), .ov_in(ov_in), .uv_in(uv_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .ov_out(ov_out), .uv_out(uv_out)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;

  function automatic logic [15:0] mk(input logic [1:0] m, input logic fm,
                                     input logic pu, input logic [4:0] pin);
    return {m, fm, pu, 7'b0, pin};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = 16'h0;
  endtask

  task automatic align();
    while ((ncyc % P) != 0) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int oe);
    hi = 0; oe = 0;
    align();
    for (int i = 0; i < P; i++) begin
      hi += int'(pwm_out);
      oe += int'(pwm_oe);
      @(negedge clk);
    end
  endtask

  task automatic settle(input int n);
    int h, o;
    for (int i = 0; i < n; i++) measure(h, o);
  endtask

  task automatic preset_fixed(input int d);
    align();
    fixed_duty = CNT_W'(d);
    write_cfg(mk(2'b11, 1'b0, 1'b1, 5'd0));
    settle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int h, o, prev;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; margin_req = 2'b00;
    target_code = '0; mlow_code = '0; mhigh_code = '0; meas_code = '0;
    fixed_duty = '0; ov_in = 1'b0; uv_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 oe", int'(pwm_oe), 0);
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 rdata", int'(cfg_rdata), 0);
    chk("R1 pin", int'(pin_sel), 0);

    // R4: disabled mode ignores margin, faults pass even with mask bit
    margin_req = 2'b10; fixed_duty = 10'd8; ov_in = 1'b1; uv_in = 1'b1;
    write_cfg(mk(2'b00, 1'b1, 1'b1, 5'h0A));
    settle(1);
    measure(h, o);
    chk("R4 off pwm count", h, 0);
    chk("R4 off oe count", o, 0);
    chk("R4 ov pass", int'(ov_out), 1);
    chk("R4 uv pass", int'(uv_out), 1);
    chk("R2 rdata", int'(cfg_rdata), int'(mk(2'b00, 1'b1, 1'b1, 5'h0A)));
    chk("R2 pin live", int'(pin_sel), 10);

    // R2: reserved bits discarded
    write_cfg(16'hFFFF);
    chk("R2 reserved zero", int'(cfg_rdata), 16'hF01F);
    write_cfg(mk(2'b00, 1'b0, 1'b1, 5'd0));
    margin_req = 2'b00; ov_in = 1'b0; uv_in = 1'b0;
    settle(2);

    // R3: configuration waits for the boundary
    align();
    write_cfg(mk(2'b11, 1'b0, 1'b1, 5'd3));
    chk("R3 not yet live", int'(pwm_oe), 0);
    measure(h, o);
    chk("R3 live after boundary oe", o, P);
    chk("R3 old duty kept", h, 0);
    measure(h, o);
    chk("R6 fixed 8", h, 8);
    chk("R2 pin after boundary", int'(pin_sel), 3);

    // R6/R11: fixed-duty sweep including clip
    for (int d = 0; d <= P + 4; d++) begin
      align();
      fixed_duty = CNT_W'(d);
      measure(h, o);
      measure(h, o);
      chk($sformatf("R6 R11 fixed duty %0d", d), h, (d > P) ? P : d);
    end

    // R5: high-impedance idle
    meas_code = 10'd300; mlow_code = 10'd100; mhigh_code = 10'd900; target_code = 10'd500;
    align();
    write_cfg(mk(2'b01, 1'b0, 1'b1, 5'd0));
    settle(1);
    measure(h, o);
    chk("R5 hiz idle oe", o, 0);
    chk("R5 hiz idle pwm", h, 0);
    align();
    margin_req = 2'b01;
    measure(h, o);
    chk("R9 request waits boundary", o, 0);
    measure(h, o);
    chk("R5 hiz margin oe", o, P);
    align();
    margin_req = 2'b00;
    measure(h, o);
    measure(h, o);
    chk("R5 hiz release oe", o, 0);

    // R7: ramp up with saturation, polarity 1
    preset_fixed(8);
    meas_code = 10'd0; target_code = 10'd500;
    align();
    write_cfg(mk(2'b10, 1'b0, 1'b1, 5'd0));
    for (int m = 0; m < 12; m++) begin
      measure(h, o);
      chk($sformatf("R7 ramp up period %0d", m), h, (8 + m > P) ? P : 8 + m);
    end

    // R8: polarity 0 reverses direction, saturates at zero
    align();
    write_cfg(mk(2'b10, 1'b0, 1'b0, 5'd0));
    for (int m = 0; m < 20; m++) begin
      measure(h, o);
      chk($sformatf("R8 R7 ramp down period %0d", m), h, (16 - m < 0) ? 0 : 16 - m);
    end

    // R7: deadband
    preset_fixed(5);
    meas_code = 10'd499; target_code = 10'd500;
    align();
    write_cfg(mk(2'b10, 1'b0, 1'b1, 5'd0));
    for (int m = 0; m < 3; m++) begin
      measure(h, o);
      chk("R7 deadband below", h, 5);
    end
    meas_code = 10'd501;
    for (int m = 0; m < 3; m++) begin
      measure(h, o);
      chk("R7 deadband above", h, 5);
    end
    align(); meas_code = 10'd502;
    measure(h, o);
    measure(h, o);
    chk("R7 outside deadband high", h, 4);
    align(); meas_code = 10'd498;
    measure(h, o);
    chk("R7 continue down", h, 3);
    measure(h, o);
    chk("R7 outside deadband low", h, 4);

    // R9: setpoint selection
    preset_fixed(8);
    meas_code = 10'd300; target_code = 10'd500; mlow_code = 10'd100; mhigh_code = 10'd900;
    margin_req = 2'b00;
    align();
    write_cfg(mk(2'b10, 1'b0, 1'b1, 5'd0));
    measure(h, o); measure(h, o);
    chk("R9 start", h, 9);
    align(); margin_req = 2'b01;
    measure(h, o); chk("R9 low p1", h, 10);
    measure(h, o); chk("R9 low p2", h, 11);
    measure(h, o); chk("R9 low setpoint lowers", h, 10);
    align(); margin_req = 2'b10;
    measure(h, o); chk("R9 high p1", h, 9);
    measure(h, o); chk("R9 high p2", h, 8);
    measure(h, o); chk("R9 high setpoint raises", h, 9);
    align(); margin_req = 2'b11; target_code = 10'd200;
    measure(h, o); chk("R9 code11 p1", h, 10);
    measure(h, o); chk("R9 code11 p2", h, 11);
    measure(h, o); chk("R9 code11 uses target", h, 10);

    // R10: fault masking
    ov_in = 1'b1; uv_in = 1'b1; margin_req = 2'b10;
    align();
    write_cfg(mk(2'b10, 1'b1, 1'b1, 5'd0));
    settle(2);
    chk("R10 ov masked", int'(ov_out), 0);
    chk("R10 uv masked", int'(uv_out), 0);
    align(); margin_req = 2'b00;
    settle(2);
    chk("R10 ov idle pass", int'(ov_out), 1);
    chk("R10 uv idle pass", int'(uv_out), 1);
    align(); margin_req = 2'b01;
    write_cfg(mk(2'b10, 1'b0, 1'b1, 5'd0));
    settle(2);
    chk("R10 mask off pass", int'(ov_out), 1);
    ov_in = 1'b0; uv_in = 1'b0; margin_req = 2'b00;

    // R7 R8: closed loop convergence, plant meas = 400 + 4*duty
    preset_fixed(2);
    target_code = 10'd432; meas_code = 10'd408;
    align();
    write_cfg(mk(2'b10, 1'b0, 1'b1, 5'd0));
    prev = 2;
    for (int m = 0; m < 30; m++) begin
      measure(h, o);
      meas_code = VW'(400 + 4 * h);
      if (m >= 22) chk("R7 closed loop in band", int'(h >= 7 && h <= 9), 1);
      prev = h;
    end
    chk("R7 closed loop final", int'(prev >= 7 && prev <= 9), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule